// File: doc/BRIEF.md
# UART FIFO Interrupt and DMA-Request Unit

This block sits between a UART serial engine and a bus host. It holds one transmit queue and one receive queue, each 16 entries deep by default. Each receive entry carries a data byte and three line-error flags. The block turns the occupancy of the two queues into DMA request lines, and into five interrupt sources that it latches in a raw status register. A software-controlled enable mask merges those sources into one group interrupt. Receive errors also drive a dedicated error interrupt that ignores the mask.

The host writes transmit bytes, reads receive bytes, and writes a control word. The control word holds the receive trigger level, the transmit trigger level and the five enable bits. The host clears latched sources by writing ones to a clear port. The serial engine pops bytes from the transmit queue and pushes received bytes together with their error flags. It also supplies a one-cycle bit-period tick and the current levels of its three modem-status inputs.

A small state machine measures receive idle time. It starts in `TO_IDLE`. It moves to `TO_WAIT` on any receive push, which also clears its tick count. A push while in `TO_WAIT` reloads the count. In `TO_WAIT` it moves to `TO_FIRED` on the tick that completes the timeout period. From `TO_WAIT` or `TO_FIRED` it returns to `TO_IDLE` when the receive queue is empty. From `TO_FIRED` it returns to `TO_WAIT` on a new push.

Top module: `uart_fifo_flow`

## Requirements
- R1: During reset both queues are empty. The raw status is 0, `dma_rx_req`, `irq_group` and `irq_err` are low, and `dma_tx_req` is high.
- R2: Both queues deliver entries in arrival order. A receive entry returns its byte on `host_rx_rdata` and its flags on `host_rx_rerr` (bit0 framing, bit1 parity, bit2 break). A write to a full transmit queue is dropped, even when a pop occurs in the same cycle. A read of an empty queue has no effect.
- R3: `dma_rx_req` is high exactly when the receive queue holds at least one entry.
- R4: `dma_tx_req` is high exactly when the transmit queue holds DEPTH/2 entries or fewer. A burst of DEPTH/2 writes issued while it is high is stored without loss.
- R5: The receive trigger code is `cfg_wdata[2:0]`. Codes 0 to 4 select DEPTH·1/8, 1/4, 1/2, 3/4 and 7/8 (2, 4, 8, 12, 14 at depth 16). Codes 5 to 7 act as 1/2. Raw status bit 1 is set while the receive count is at or above the threshold.
- R6: The transmit trigger code is `cfg_wdata[5:3]` and uses the same encoding. Raw status bit 2 is set while the transmit count is at or below the threshold.
- R7: Raw status bit 0 is set while any of `modem_cts`, `modem_dcd` or `modem_dsr` is high.
- R8: Raw status bit 3 is set once the receive queue is non-empty and TIMEOUT_BITS (32) bit ticks have passed with no push. Each push restarts the count. Emptying the queue cancels the timeout.
- R9: A receive push with any flag set, or a push into a full receive queue, sets raw status bit 4 in that cycle. Bit 4 drives `irq_err` regardless of the mask. A push into a full queue is discarded and sets `stat_overrun`.
- R10: `irq_group` is the OR of the raw status bits whose enable is set. The enables are `cfg_wdata[10:6]` for bits 0 to 4.
- R11: Raw status bits are sticky. Writing 1 to a bit of `icr_wdata` clears it, and a level source whose condition still holds sets it again in the same edge. Clearing bit 4 also clears `stat_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_tx_we | input | 1 | Host writes a transmit byte |
| host_tx_wdata | input | 8 | Transmit byte |
| host_rx_re | input | 1 | Host reads (pops) the receive head |
| host_rx_rdata | output | 8 | Receive head byte |
| host_rx_rerr | output | 3 | Receive head error flags |
| cfg_we | input | 1 | Control register write |
| cfg_wdata | input | 11 | Trigger codes and enables |
| icr_we | input | 1 | Status clear strobe |
| icr_wdata | input | 5 | Write-1 clear bits |
| stat_ris | output | 5 | Raw latched interrupt status |
| stat_tx_count | output | CNT_W (5) | Transmit occupancy |
| stat_rx_count | output | CNT_W (5) | Receive occupancy |
| stat_overrun | output | 1 | Sticky receive overrun flag |
| eng_tx_valid | output | 1 | Transmit queue non-empty |
| eng_tx_data | output | 8 | Transmit head byte |
| eng_tx_pop | input | 1 | Engine consumes the transmit head |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_err | input | 3 | Framing, parity, break flags |
| bit_tick | input | 1 | One pulse per bit period |
| modem_cts | input | 1 | Clear-to-send level |
| modem_dcd | input | 1 | Carrier-detect level |
| modem_dsr | input | 1 | Data-set-ready level |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| irq_group | output | 1 | Masked group interrupt |
| irq_err | output | 1 | Dedicated error interrupt |

## Verification
The assertions check the following on every cycle:
- the receive request follows emptiness;
- the transmit request implies room for half a queue;
- the transmit count never exceeds the depth;
- an error push raises `irq_err` at the next edge;
- modem levels set bit 0, and clearing bit 0 takes effect when the lines are low;
- a zero raw status keeps the group line low.

The bench scenarios cover what the assertions cannot:
- the threshold table for every one of the eight trigger codes at every fill level;
- end-to-end data and flag order;
- the exact 32nd-tick timeout edge, its restart and its cancel;
- overrun discard;
- the full enable-mask sweep.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

    // Raw status bit positions
    localparam int SRC_MODEM = 0;
    localparam int SRC_RXLVL = 1;
    localparam int SRC_TXLVL = 2;
    localparam int SRC_RXTO  = 3;
    localparam int SRC_ERR   = 4;
    localparam int NUM_SRC   = 5;

    localparam int DATA_W = 8;
    localparam int ERR_W  = 3;
    localparam int LVL_W  = 3;
    localparam int CFG_W  = 2 * LVL_W + NUM_SRC;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_WAIT  = 2'd1,
        TO_FIRED = 2'd2
    } to_state_e;

endpackage

// File: rtl/flow_fifo.sv
module flow_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
    import uart_flow_pkg::*;
#(
    parameter int TIMEOUT_BITS = 32,
    localparam int TW = $clog2(TIMEOUT_BITS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_push,
    input  logic rx_empty,
    input  logic bit_tick,
    output logic expired
);

    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_BITS - 1);

    to_state_e     state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (rx_push) begin
            state_d = TO_WAIT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TO_IDLE: begin
                    cnt_d = '0;
                end
                TO_WAIT: begin
                    if (rx_empty) begin
                        state_d = TO_IDLE;
                        cnt_d   = '0;
                    end else if (bit_tick) begin
                        if (cnt_q == LAST) begin
                            state_d = TO_FIRED;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                TO_FIRED: begin
                    if (rx_empty) begin
                        state_d = TO_IDLE;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = TO_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        expired = (state_q == TO_FIRED);
    end

endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cond,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_bits,
    input  logic [NSRC-1:0] enable,
    output logic [NSRC-1:0] ris,
    output logic            irq_group
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ris[i] <= 1'b0;
            end else begin
                ris[i] <= (ris[i] && !(clr_we && clr_bits[i])) || cond[i];
            end
        end
    end

    assign irq_group = |(ris & enable);

endmodule

// File: rtl/uart_fifo_flow.sv
module uart_fifo_flow
    import uart_flow_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int TIMEOUT_BITS = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_tx_we,
    input  logic [DATA_W-1:0] host_tx_wdata,
    input  logic              host_rx_re,
    output logic [DATA_W-1:0] host_rx_rdata,
    output logic [ERR_W-1:0]  host_rx_rerr,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              icr_we,
    input  logic [NUM_SRC-1:0] icr_wdata,
    output logic [NUM_SRC-1:0] stat_ris,
    output logic [CNT_W-1:0]  stat_tx_count,
    output logic [CNT_W-1:0]  stat_rx_count,
    output logic              stat_overrun,
    output logic              eng_tx_valid,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic [ERR_W-1:0]  eng_rx_err,
    input  logic              bit_tick,
    input  logic              modem_cts,
    input  logic              modem_dcd,
    input  logic              modem_dsr,
    output logic              dma_rx_req,
    output logic              dma_tx_req,
    output logic              irq_group,
    output logic              irq_err
);

    localparam int RXW = DATA_W + ERR_W;

    // Control register
    logic [LVL_W-1:0]   rx_lvl_q;
    logic [LVL_W-1:0]   tx_lvl_q;
    logic [NUM_SRC-1:0] enable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_lvl_q <= LVL_W'(2);
            tx_lvl_q <= LVL_W'(2);
            enable_q <= '0;
        end else if (cfg_we) begin
            rx_lvl_q <= cfg_wdata[LVL_W-1:0];
            tx_lvl_q <= cfg_wdata[2*LVL_W-1:LVL_W];
            enable_q <= cfg_wdata[CFG_W-1:2*LVL_W];
        end
    end

    function automatic logic [CNT_W-1:0] level_to_count(input logic [LVL_W-1:0] code);
        case (code)
            3'd0:    return CNT_W'(DEPTH / 8);
            3'd1:    return CNT_W'(DEPTH / 4);
            3'd2:    return CNT_W'(DEPTH / 2);
            3'd3:    return CNT_W'((DEPTH * 3) / 4);
            3'd4:    return CNT_W'((DEPTH * 7) / 8);
            default: return CNT_W'(DEPTH / 2);
        endcase
    endfunction

    // Transmit queue
    logic tx_full, tx_empty;

    flow_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (host_tx_we),
        .push_data (host_tx_wdata),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .count     (stat_tx_count),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    // Receive queue: {flags, byte}
    logic [RXW-1:0] rx_head;
    logic           rx_full, rx_empty;

    flow_fifo #(.WIDTH(RXW), .DEPTH(DEPTH)) u_rx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (eng_rx_push),
        .push_data ({eng_rx_err, eng_rx_data}),
        .pop       (host_rx_re),
        .head      (rx_head),
        .count     (stat_rx_count),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    assign host_rx_rdata = rx_head[DATA_W-1:0];
    assign host_rx_rerr  = rx_head[RXW-1:DATA_W];
    assign eng_tx_valid  = !tx_empty;

    // Idle timeout
    logic to_expired;

    rx_idle_timer #(.TIMEOUT_BITS(TIMEOUT_BITS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_push  (eng_rx_push),
        .rx_empty (rx_empty),
        .bit_tick (bit_tick),
        .expired  (to_expired)
    );

    // Source conditions
    logic               overrun_ev;
    logic [NUM_SRC-1:0] cond;

    assign overrun_ev       = eng_rx_push && rx_full;
    assign cond[SRC_MODEM]  = modem_cts || modem_dcd || modem_dsr;
    assign cond[SRC_RXLVL]  = (stat_rx_count >= level_to_count(rx_lvl_q));
    assign cond[SRC_TXLVL]  = (stat_tx_count <= level_to_count(tx_lvl_q));
    assign cond[SRC_RXTO]   = to_expired;
    assign cond[SRC_ERR]    = (eng_rx_push && (|eng_rx_err)) || overrun_ev;

    irq_merge #(.NSRC(NUM_SRC)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond      (cond),
        .clr_we    (icr_we),
        .clr_bits  (icr_wdata),
        .enable    (enable_q),
        .ris       (stat_ris),
        .irq_group (irq_group)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_overrun <= 1'b0;
        end else begin
            stat_overrun <= (stat_overrun && !(icr_we && icr_wdata[SRC_ERR])) || overrun_ev;
        end
    end

    assign irq_err    = stat_ris[SRC_ERR];
    assign dma_rx_req = !rx_empty;
    assign dma_tx_req = (stat_tx_count <= CNT_W'(DEPTH / 2));

endmodule

// File: rtl/uart_flow_chk.sv
module uart_flow_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             icr_we,
    input logic [4:0]       icr_wdata,
    input logic [4:0]       stat_ris,
    input logic [CNT_W-1:0] stat_tx_count,
    input logic [CNT_W-1:0] stat_rx_count,
    input logic             eng_rx_push,
    input logic [2:0]       eng_rx_err,
    input logic             modem_cts,
    input logic             modem_dcd,
    input logic             modem_dsr,
    input logic             dma_rx_req,
    input logic             dma_tx_req,
    input logic             irq_group,
    input logic             irq_err
);

    p_tx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_tx_count <= CNT_W'(DEPTH));

    p_rx_req_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && stat_rx_count == '0) |=> dma_rx_req);

    p_rx_req_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rx_count == '0) |-> !dma_rx_req);

    p_tx_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_req |-> (CNT_W'(DEPTH) - stat_tx_count) >= CNT_W'(DEPTH / 2));

    p_modem_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (modem_cts || modem_dcd || modem_dsr) |=> stat_ris[0]);

    p_err_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && (|eng_rx_err)) |=> irq_err);

    p_group_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ris == '0) |-> !irq_group);

    p_modem_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (icr_we && icr_wdata[0] && !(modem_cts || modem_dcd || modem_dsr)) |=> !stat_ris[0]);

endmodule

bind uart_fifo_flow uart_flow_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .icr_we        (icr_we),
    .icr_wdata     (icr_wdata),
    .stat_ris      (stat_ris),
    .stat_tx_count (stat_tx_count),
    .stat_rx_count (stat_rx_count),
    .eng_rx_push   (eng_rx_push),
    .eng_rx_err    (eng_rx_err),
    .modem_cts     (modem_cts),
    .modem_dcd     (modem_dcd),
    .modem_dsr     (modem_dsr),
    .dma_rx_req    (dma_rx_req),
    .dma_tx_req    (dma_tx_req),
    .irq_group     (irq_group),
    .irq_err       (irq_err)
);

// File: tb/sim_uart_fifo_flow.sv
module sim_uart_fifo_flow;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_tx_we = 1'b0;
    logic [7:0]  host_tx_wdata = '0;
    logic        host_rx_re = 1'b0;
    logic [7:0]  host_rx_rdata;
    logic [2:0]  host_rx_rerr;
    logic        cfg_we = 1'b0;
    logic [10:0] cfg_wdata = '0;
    logic        icr_we = 1'b0;
    logic [4:0]  icr_wdata = '0;
    logic [4:0]  stat_ris;
    logic [4:0]  stat_tx_count;
    logic [4:0]  stat_rx_count;
    logic        stat_overrun;
    logic        eng_tx_valid;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_pop = 1'b0;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic [2:0]  eng_rx_err = '0;
    logic        bit_tick = 1'b0;
    logic        modem_cts = 1'b0;
    logic        modem_dcd = 1'b0;
    logic        modem_dsr = 1'b0;
    logic        dma_rx_req, dma_tx_req, irq_group, irq_err;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_fifo_flow u0 (.*);

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(); @(negedge clk); endtask

    task automatic set_cfg(input int rxl, input int txl, input int en);
        cfg_we = 1'b1;
        cfg_wdata = {5'(en), 3'(txl), 3'(rxl)};
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic clear(input logic [4:0] bits);
        icr_we = 1'b1;
        icr_wdata = bits;
        cyc();
        icr_we = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] d, input logic [2:0] e);
        eng_rx_push = 1'b1;
        eng_rx_data = d;
        eng_rx_err = e;
        cyc();
        eng_rx_push = 1'b0;
        eng_rx_err = '0;
    endtask

    task automatic host_read();
        host_rx_re = 1'b1;
        cyc();
        host_rx_re = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] d);
        host_tx_we = 1'b1;
        host_tx_wdata = d;
        cyc();
        host_tx_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            cyc();
        end
        bit_tick = 1'b0;
    endtask

    function automatic int thr(input int code);
        case (code)
            0: return DEPTH / 8;
            1: return DEPTH / 4;
            2: return DEPTH / 2;
            3: return DEPTH * 3 / 4;
            4: return DEPTH * 7 / 8;
            default: return DEPTH / 2;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=0 exp=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc(); cyc(); cyc();
        // R1 reset state
        chk(stat_ris == 0, "R1 ris", stat_ris, 0);
        chk(!dma_rx_req && dma_tx_req, "R1 dma", {dma_rx_req, dma_tx_req}, 1);
        chk(!irq_group && !irq_err, "R1 irq", {irq_group, irq_err}, 0);
        chk(stat_rx_count == 0 && stat_tx_count == 0, "R1 counts", stat_rx_count + stat_tx_count, 0);
        rst_n = 1'b1;
        cyc();

        // R5/R3/R2: receive threshold sweep, every code and fill level
        for (int code = 0; code < 8; code++) begin
            set_cfg(code, 2, 0);
            clear(5'b00010);
            chk(stat_ris[1] == 1'b0, "R5 empty", stat_ris[1], 0);
            for (int n = 1; n <= DEPTH; n++) begin
                rx_push(8'(code * 16 + n), 3'(n % 8));
                clear(5'b00010);
                chk(stat_ris[1] == (n >= thr(code)), "R5 level", stat_ris[1], int'(n >= thr(code)));
                chk(dma_rx_req == 1'b1, "R3 req", dma_rx_req, 1);
            end
            for (int n = 1; n <= DEPTH; n++) begin
                chk(host_rx_rdata == 8'(code * 16 + n), "R2 rx order", host_rx_rdata, code * 16 + n);
                chk(host_rx_rerr == 3'(n % 8), "R2 rx flags", host_rx_rerr, n % 8);
                host_read();
            end
            chk(dma_rx_req == 1'b0, "R3 drained", dma_rx_req, 0);
            host_read();
            chk(stat_rx_count == 0, "R2 empty read", stat_rx_count, 0);
        end
        clear(5'b10000);

        // R6/R4/R2: transmit threshold sweep
        for (int code = 0; code < 8; code++) begin
            set_cfg(2, code, 0);
            for (int n = 1; n <= DEPTH; n++) begin
                host_write(8'(200 - code * 16 - n));
                clear(5'b00100);
                chk(stat_ris[2] == (n <= thr(code)), "R6 level", stat_ris[2], int'(n <= thr(code)));
                chk(dma_tx_req == (n <= DEPTH / 2), "R4 req", dma_tx_req, int'(n <= DEPTH / 2));
            end
            chk(stat_tx_count == 5'(DEPTH), "R4 burst kept", stat_tx_count, DEPTH);
            host_write(8'hEE);
            chk(stat_tx_count == 5'(DEPTH), "R2 full drop", stat_tx_count, DEPTH);
            for (int n = 1; n <= DEPTH; n++) begin
                chk(eng_tx_valid && eng_tx_data == 8'(200 - code * 16 - n), "R2 tx order",
                    eng_tx_data, 200 - code * 16 - n);
                eng_tx_pop = 1'b1;
                cyc();
                eng_tx_pop = 1'b0;
            end
            chk(!eng_tx_valid, "R2 tx empty", eng_tx_valid, 0);
        end

        // R7/R11: modem levels
        for (int m = 0; m < 8; m++) begin
            {modem_cts, modem_dcd, modem_dsr} = 3'(m);
            clear(5'b00001);
            chk(stat_ris[0] == (m != 0), "R7 modem", stat_ris[0], int'(m != 0));
        end
        {modem_cts, modem_dcd, modem_dsr} = 3'b000;
        cyc();
        chk(stat_ris[0] == 1'b1, "R11 sticky", stat_ris[0], 1);
        clear(5'b00001);
        chk(stat_ris[0] == 1'b0, "R11 cleared", stat_ris[0], 0);

        // R10: enable mask sweep with raw status 00101
        modem_dsr = 1'b1;
        set_cfg(2, 2, 0);
        clear(5'b11010);
        chk(stat_ris == 5'b00101, "R10 setup", stat_ris, 5);
        for (int m = 0; m < 32; m++) begin
            set_cfg(2, 2, m);
            chk(irq_group == |(5'(m) & 5'b00101), "R10 group", irq_group, int'(|(5'(m) & 5'b00101)));
            chk(!irq_err, "R10 err quiet", irq_err, 0);
        end
        modem_dsr = 1'b0;
        set_cfg(2, 2, 0);
        clear(5'b11111);

        // R9: error flags and overrun
        rx_push(8'h5A, 3'b001);
        chk(irq_err && !irq_group, "R9 err unmasked", {irq_err, irq_group}, 2);
        chk(host_rx_rerr == 3'b001 && host_rx_rdata == 8'h5A, "R9 head", host_rx_rerr, 1);
        clear(5'b10000);
        chk(!irq_err, "R11 err clear", irq_err, 0);
        for (int n = 1; n < DEPTH; n++) rx_push(8'(n), 3'b000);
        clear(5'b10000);
        chk(!irq_err && !stat_overrun, "R9 no err", {irq_err, stat_overrun}, 0);
        rx_push(8'hFF, 3'b000);
        chk(irq_err && stat_overrun, "R9 overrun", {irq_err, stat_overrun}, 3);
        chk(stat_rx_count == 5'(DEPTH), "R9 discard", stat_rx_count, DEPTH);
        clear(5'b10000);
        chk(!stat_overrun, "R11 ovr clear", stat_overrun, 0);
        for (int n = 0; n < DEPTH; n++) begin
            if (n == DEPTH - 1)
                chk(host_rx_rdata == 8'(DEPTH - 1), "R9 last kept", host_rx_rdata, DEPTH - 1);
            host_read();
        end

        // R8: receive timeout
        set_cfg(2, 2, 5'b01000);
        clear(5'b11111);
        rx_push(8'h11, 3'b000);
        ticks(31);
        cyc();
        chk(stat_ris[3] == 1'b0, "R8 before", stat_ris[3], 0);
        ticks(1);
        cyc();
        chk(stat_ris[3] && irq_group, "R8 fired", stat_ris[3], 1);
        rx_push(8'h22, 3'b000);
        clear(5'b01000);
        chk(stat_ris[3] == 1'b0, "R8 restart clear", stat_ris[3], 0);
        ticks(31);
        cyc();
        chk(stat_ris[3] == 1'b0, "R8 restarted", stat_ris[3], 0);
        host_read();
        host_read();
        ticks(40);
        cyc();
        chk(stat_ris[3] == 1'b0, "R8 cancel", stat_ris[3], 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule